// File: doc/BRIEF.md
# Prefix Immediate Extension Decoder

This decode-stage unit sits on a stream of 16-bit instruction words that arrives at up to one word per cycle. Long constants are built by placing one or more prefix words ahead of an operation. Each prefix carries twelve bits of payload. The operation's own eight-bit field supplies the least significant bits of the finished constant. The unit merges each prefix group into the immediate of the next operation that uses one. It drops pending prefix bits when the next operation has no immediate. When a conditional skip is requested, it suppresses a whole prefix-plus-operation unit.

The unit presents every non-prefix word one cycle after it is accepted. With it come the finished immediate, sign-extended to the data width, and an issue flag that is low for a skipped operation. Prefix words produce no output. A constant that fits in the eight-bit field goes out with no extra cycle. Each additional prefix costs one cycle.

The control is a three-state machine:
- IDLE: no prefix is pending.
- ACCUM: one or more prefixes are held.
- SKIP: the next prefix-plus-operation unit is discarded.

The transitions are:
- IDLE to ACCUM: a prefix word arrives.
- ACCUM to ACCUM: a further prefix word arrives.
- ACCUM to IDLE: a non-prefix word arrives.
- IDLE or ACCUM to SKIP: a skip request arrives.
- SKIP to SKIP: a prefix word arrives.
- SKIP to IDLE: a non-prefix word arrives.
- Any state holds on a cycle with no valid word.

Top module: `pfx_imm_decoder`

## Requirements
- R1: After reset, `out_valid` and `out_issue` are 0 and no prefix bits are pending. A reset that lands between a prefix and its operation discards that prefix.
- R2: The opcode is word bits [15:12]. Opcode 4'hF is a prefix, with payload in bits [11:0]. Opcodes 0 to 7 use an immediate, whose own field is bits [7:0]. Opcodes 8 to 14 do not use one. A valid non-prefix word appears on `out_word` with `out_valid`=1 one cycle after it is accepted. A prefix word gives `out_valid`=0.
- R3: An immediate-using word with no pending prefix outputs its eight-bit field sign-extended to DATA_W. It takes no extra cycle.
- R4: One prefix followed by an immediate-using word yields the sign-extension of {payload, own field}.
- R5: Chained prefixes each shift the pending value left by 12 and append their payload. The result is truncated to DATA_W. Each prefix adds one cycle.
- R6: A non-immediate word (opcodes 8 to 14) outputs `out_imm`=0 and `out_uses_imm`=0, and it drops any pending prefix bits. The next immediate word sees none of those bits.
- R7: A cycle with `in_valid`=0 changes neither the state nor the pending prefix bits.
- R8: When `skip_req` is high in IDLE or ACCUM, the current word is handled normally. After that, all following prefix words are dropped. The first following non-prefix word comes out with `out_valid`=1 and `out_issue`=0, and normal issue resumes after it. A skip request on a cycle with no valid word also arms the skip.
- R9: A skip request clears any pending prefix bits. Prefix words inside a skip are not accumulated, so the skipped word's `out_imm` is its own field sign-extended.
- R10: `skip_req` is ignored while in SKIP. The word after the skipped one issues normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction word is present this cycle |
| in_word | input | 16 | Instruction word |
| skip_req | input | 1 | Conditional skip taken; discard the next prefix-plus-operation unit |
| out_valid | output | 1 | A non-prefix word is presented |
| out_issue | output | 1 | The presented word is to execute (0 when skipped) |
| out_word | output | 16 | The presented instruction word |
| out_imm | output | DATA_W | Fully extended immediate |
| out_uses_imm | output | 1 | The presented opcode uses an immediate |

## Verification
The merge is tried with these input patterns, each chosen to separate one possible fault from the others:
- **Unprefixed words with positive and negative own fields.** These show that sign extension starts from bit 7.
- **Single prefixes with positive and negative payloads.** These show that the prefix sign reaches the top of the data word.
- **A triple prefix.** Its bits spill past 32, which exposes the shift amount and the truncation.
- **A prefix before a non-immediate word, then a plain immediate word.** This shows that the prefix bits are discarded and not carried forward.
- **A bubble between a prefix and its operation.** This proves that the pending bits survive idle cycles.
- **Skip sequences.** These cover a skip over a prefixed operation, a skip request repeated during a skip, a skip request on a prefix word and a skip request on an empty cycle. Together they separate whole-unit suppression from single-word suppression and from leaking prefix bits.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int PFX_W   = 12;
    localparam int OWN_W   = 8;
    localparam int NUM_OPC = 1 << OPC_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_SKIP  = 2'd2
    } pfx_state_e;
endpackage

// File: rtl/pfx_opdecode.sv
module pfx_opdecode
    import pfx_pkg::*;
#(
    parameter logic [OPC_W-1:0]   PFX_OPC  = 4'hF,
    parameter logic [NUM_OPC-1:0] IMM_MASK = 16'h00FF
) (
    input  logic [INSTR_W-1:0] word,
    output logic               is_pfx,
    output logic               uses_imm,
    output logic [PFX_W-1:0]   payload,
    output logic [OWN_W-1:0]   own_field
);
    logic [OPC_W-1:0]   opc;
    logic [NUM_OPC-1:0] imm_tab;

    // per-opcode table: the prefix opcode never counts as an immediate user
    for (genvar g = 0; g < NUM_OPC; g++) begin : g_tab
        assign imm_tab[g] = IMM_MASK[g] && (OPC_W'(g) != PFX_OPC);
    end

    assign opc       = word[INSTR_W-1 -: OPC_W];
    assign is_pfx    = (opc == PFX_OPC);
    assign uses_imm  = imm_tab[opc];
    assign payload   = word[PFX_W-1:0];
    assign own_field = word[OWN_W-1:0];
endmodule

// File: rtl/pfx_pending.sv
module pfx_pending
    import pfx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load_first,
    input  logic              shift_in,
    input  logic [PFX_W-1:0]  payload,
    output logic [DATA_W-1:0] pending
);
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] first_val;
    logic [DATA_W-1:0] shift_val;

    // first prefix is held already sign-extended, so later stages never need a length count
    assign first_val = DATA_W'($signed(payload));

    if (DATA_W > PFX_W) begin : g_wide
        assign shift_val = (pend_q << PFX_W) | DATA_W'(payload);
    end else begin : g_narrow
        assign shift_val = DATA_W'(payload);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (clr) begin
            pend_q <= '0;
        end else if (load_first) begin
            pend_q <= first_val;
        end else if (shift_in) begin
            pend_q <= shift_val;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/pfx_imm_build.sv
module pfx_imm_build
    import pfx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              has_pfx,
    input  logic              uses_imm,
    input  logic [DATA_W-1:0] pending,
    input  logic [OWN_W-1:0]  own_field,
    output logic [DATA_W-1:0] imm
);
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] plain;

    if (DATA_W > OWN_W) begin : g_wide
        assign merged = (pending << OWN_W) | DATA_W'(own_field);
    end else begin : g_narrow
        assign merged = DATA_W'(own_field);
    end

    assign plain = DATA_W'($signed(own_field));

    always_comb begin
        if (!uses_imm) begin
            imm = '0;
        end else if (has_pfx) begin
            imm = merged;
        end else begin
            imm = plain;
        end
    end
endmodule

// File: rtl/pfx_imm_decoder.sv
module pfx_imm_decoder
    import pfx_pkg::*;
#(
    parameter int                 DATA_W   = 32,
    parameter logic [OPC_W-1:0]   PFX_OPC  = 4'hF,
    parameter logic [NUM_OPC-1:0] IMM_MASK = 16'h00FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_word,
    input  logic               skip_req,
    output logic               out_valid,
    output logic               out_issue,
    output logic [INSTR_W-1:0] out_word,
    output logic [DATA_W-1:0]  out_imm,
    output logic               out_uses_imm
);
    pfx_state_e        state_q;
    pfx_state_e        state_d;
    logic              is_pfx;
    logic              uses_imm;
    logic [PFX_W-1:0]  payload;
    logic [OWN_W-1:0]  own_field;
    logic [DATA_W-1:0] pending;
    logic [DATA_W-1:0] imm_c;
    logic              has_pfx;
    logic              pend_clr;
    logic              pend_first;
    logic              pend_shift;
    logic              op_word;

    pfx_opdecode #(
        .PFX_OPC  (PFX_OPC),
        .IMM_MASK (IMM_MASK)
    ) u_dec (
        .word      (in_word),
        .is_pfx    (is_pfx),
        .uses_imm  (uses_imm),
        .payload   (payload),
        .own_field (own_field)
    );

    pfx_pending #(
        .DATA_W (DATA_W)
    ) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (pend_clr),
        .load_first (pend_first),
        .shift_in   (pend_shift),
        .payload    (payload),
        .pending    (pending)
    );

    pfx_imm_build #(
        .DATA_W (DATA_W)
    ) u_build (
        .has_pfx   (has_pfx),
        .uses_imm  (uses_imm),
        .pending   (pending),
        .own_field (own_field),
        .imm       (imm_c)
    );

    assign has_pfx = (state_q == ST_ACCUM);
    assign op_word = in_valid && !is_pfx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and pending-register control
    always_comb begin
        state_d    = state_q;
        pend_clr   = 1'b0;
        pend_first = 1'b0;
        pend_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (skip_req) begin
                    state_d  = ST_SKIP;
                    pend_clr = 1'b1;
                end else if (in_valid && is_pfx) begin
                    state_d    = ST_ACCUM;
                    pend_first = 1'b1;
                end
            end
            ST_ACCUM: begin
                if (skip_req) begin
                    state_d  = ST_SKIP;
                    pend_clr = 1'b1;
                end else if (in_valid && is_pfx) begin
                    pend_shift = 1'b1;
                end else if (op_word) begin
                    state_d  = ST_IDLE;
                    pend_clr = 1'b1;
                end
            end
            ST_SKIP: begin
                if (op_word) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d  = ST_IDLE;
                pend_clr = 1'b1;
            end
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_issue    <= 1'b0;
            out_word     <= '0;
            out_imm      <= '0;
            out_uses_imm <= 1'b0;
        end else begin
            out_valid <= op_word;
            out_issue <= op_word && (state_q != ST_SKIP);
            if (op_word) begin
                out_word     <= in_word;
                out_imm      <= imm_c;
                out_uses_imm <= uses_imm;
            end
        end
    end
endmodule

// File: rtl/pfx_imm_decoder_chk.sv
module pfx_imm_decoder_chk
    import pfx_pkg::*;
#(
    parameter int                 DATA_W   = 32,
    parameter logic [OPC_W-1:0]   PFX_OPC  = 4'hF,
    parameter logic [NUM_OPC-1:0] IMM_MASK = 16'h00FF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] in_word,
    input logic               skip_req,
    input logic               out_valid,
    input logic               out_issue,
    input logic [INSTR_W-1:0] out_word,
    input logic [DATA_W-1:0]  out_imm,
    input logic               out_uses_imm,
    input pfx_state_e         state_q
);
    logic [OPC_W-1:0] opc;
    assign opc = in_word[INSTR_W-1 -: OPC_W];

    // R2
    prefix_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == PFX_OPC) |=> !out_valid);

    // R2
    op_presented_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc != PFX_OPC) |=> (out_valid && out_word == $past(in_word)));

    // R3
    plain_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc != PFX_OPC && IMM_MASK[opc] && state_q != ST_ACCUM)
        |=> (out_imm == DATA_W'($signed($past(in_word[OWN_W-1:0])))));

    // R6
    no_imm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc != PFX_OPC && !IMM_MASK[opc]) |=> (out_imm == '0 && !out_uses_imm));

    // R8
    skip_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP && in_valid && opc != PFX_OPC) |=> (out_valid && !out_issue));

    // R8
    skip_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && state_q != ST_SKIP) |=> (state_q == ST_SKIP));

    // R7
    bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !skip_req) |=> $stable(state_q));

    // R8
    issue_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_issue |-> out_valid);

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!out_valid && !out_issue);
        end
    end

    logic unused_ok;
    assign unused_ok = ^{skip_req, out_uses_imm};
endmodule

bind pfx_imm_decoder pfx_imm_decoder_chk #(
    .DATA_W   (DATA_W),
    .PFX_OPC  (PFX_OPC),
    .IMM_MASK (IMM_MASK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_word      (in_word),
    .skip_req     (skip_req),
    .out_valid    (out_valid),
    .out_issue    (out_issue),
    .out_word     (out_word),
    .out_imm      (out_imm),
    .out_uses_imm (out_uses_imm),
    .state_q      (state_q)
);

// File: tb/pfx_imm_decoder_tb.sv
module pfx_imm_decoder_tb;
    localparam int DATA_W = 32;
    localparam int NVEC   = 26;
    localparam int VW     = 4 + 1 + 16 + 1 + 1 + 1 + 1 + 32;

    // {tag, valid, word, skip, exp_valid, exp_issue, exp_uses, exp_imm}
    localparam logic [0:NVEC-1][VW-1:0] VEC = '{
        {4'd3,  1'b1, 16'h1305, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0005}, // R3 positive
        {4'd3,  1'b1, 16'h20F0, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFF0}, // R3 negative
        {4'd2,  1'b1, 16'hF123, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R2 prefix silent
        {4'd4,  1'b1, 16'h1045, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0001_2345}, // R4
        {4'd2,  1'b1, 16'hF800, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R2
        {4'd4,  1'b1, 16'h3001, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFFF8_0001}, // R4 negative prefix
        {4'd5,  1'b1, 16'hF001, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R5
        {4'd5,  1'b1, 16'hF234, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R5
        {4'd5,  1'b1, 16'hF567, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R5
        {4'd5,  1'b1, 16'h4089, 1'b0, 1'b1, 1'b1, 1'b1, 32'h2345_6789}, // R5 truncated
        {4'd6,  1'b1, 16'hFABC, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R6
        {4'd6,  1'b1, 16'h9500, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},         // R6 no immediate
        {4'd6,  1'b1, 16'h1007, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0007}, // R6 bits dropped
        {4'd7,  1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R7
        {4'd7,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R7 bubble
        {4'd7,  1'b1, 16'h1080, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FF80}, // R7 held
        {4'd8,  1'b1, 16'hA000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0},         // R8 skip source
        {4'd8,  1'b1, 16'hF111, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R8
        {4'd9,  1'b1, 16'h1022, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0022}, // R9 skipped
        {4'd8,  1'b1, 16'h1033, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0033}, // R8 resumes
        {4'd10, 1'b1, 16'hA000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0},         // R10
        {4'd10, 1'b1, 16'h1044, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0044}, // R10 ignored
        {4'd10, 1'b1, 16'h1055, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0055}, // R10
        {4'd9,  1'b1, 16'hF321, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},         // R9
        {4'd9,  1'b1, 16'h1066, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0066}, // R9 cleared
        {4'd9,  1'b1, 16'h1077, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0077}  // R9
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [15:0]       in_word = '0;
    logic              skip_req = 1'b0;
    logic              out_valid;
    logic              out_issue;
    logic [15:0]       out_word;
    logic [DATA_W-1:0] out_imm;
    logic              out_uses_imm;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfx_imm_decoder #(.DATA_W(DATA_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .skip_req     (skip_req),
        .out_valid    (out_valid),
        .out_issue    (out_issue),
        .out_word     (out_word),
        .out_imm      (out_imm),
        .out_uses_imm (out_uses_imm)
    );

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] w, input logic s);
        in_valid = v;
        in_word  = w;
        skip_req = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "out_issue", 64'(out_issue), 64'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] e;
            string rq;
            e = VEC[i];
            rq = $sformatf("R%0d", e[VW-1 -: 4]);
            step(e[52], e[51:36], e[35]);
            check(rq, "out_valid", 64'(out_valid), 64'(e[34]));
            check(rq, "out_issue", 64'(out_issue), 64'(e[33]));
            if (e[34]) begin
                check(rq, "out_word", 64'(out_word), 64'(e[51:36]));
                check(rq, "out_uses_imm", 64'(out_uses_imm), 64'(e[32]));
                check(rq, "out_imm", 64'(out_imm), 64'(e[31:0]));
            end
        end

        // R1: reset between a prefix and its operation discards the prefix
        step(1'b1, 16'hF7FF, 1'b0);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        step(1'b1, 16'h1012, 1'b0);
        check("R1", "out_imm after reset", 64'(out_imm), 64'h12);
        check("R1", "out_issue after reset", 64'(out_issue), 64'd1);

        // R8: skip request on an empty cycle arms the skip
        step(1'b0, 16'h0000, 1'b1);
        check("R8", "out_valid empty", 64'(out_valid), 64'd0);
        step(1'b1, 16'h1001, 1'b0);
        check("R8", "skipped out_valid", 64'(out_valid), 64'd1);
        check("R8", "skipped out_issue", 64'(out_issue), 64'd0);
        step(1'b1, 16'h1002, 1'b0);
        check("R8", "resume out_issue", 64'(out_issue), 64'd1);
        check("R3", "resume out_imm", 64'(out_imm), 64'h2);

        step(1'b0, 16'h0000, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule